// File: doc/BRIEF.md
# Pulse-Width and Rate-Multiplier DAC Generator

This block drives eight digital outputs whose average level, once smoothed by an external RC low-pass filter, gives a 10-bit analog value per channel. Each channel's value has two parts. The upper six bits set the width of a pulse inside a fixed 64-clock period. The lower four bits drive a binary rate multiplier, which lengthens that pulse by one clock in selected periods of a 16-period frame. The average therefore resolves 1/1024 of full scale, while the basic period stays short enough for a simple filter.

Software programs the block through a small synchronous register port. There is one pulse register per channel, holding a polarity bit and the six-bit weight. Four dither registers each carry the four-bit dither values for a pair of channels. One enable register gates each output. Register writes are captured at once, but each channel copies its configuration into an active set only at the boundary between two periods. A pulse that has already started is never cut short or stretched.

Top module: `pwm_brm_dac`

## Requirements
- R1: Register addresses are 0–7 for the pulse registers of channels 0–7, 8–11 for the dither registers and 12 for the enable register. After reset, the pulse registers read 0x80, the dither registers read 0x00 and the enable register reads 0x80, so only channel 7 is enabled.
- R2: A pulse register returns 1 in bit 7 whatever was written. Bit 6 (polarity) and bits 5:0 (weight) return the last written values.
- R3: Dither register 8+k holds the 4-bit dither value of channel 2k in bits 3:0 and that of channel 2k+1 in bits 7:4. It reads back as written.
- R4: A period is 64 clocks. A 4-bit frame counter advances by one at the end of each period and wraps after 16 periods.
- R5: For an enabled, non-inverted channel with weight W and dither D, the output is high for exactly 16·W + D clocks in every 1024 consecutive clocks.
- R6: Dither bit 3 extends 8 periods per frame, bit 2 extends 4, bit 1 extends 2 and bit 0 extends 1. No period is selected by two bits.
- R7: The extra clock is placed at the start of the period, ahead of the normal pulse. The falling edges of a running channel are therefore always 64 clocks apart, while its rising edges move.
- R8: With polarity set (bit 6 = 1), an enabled channel's output is the complement, high for 1024 − (16·W + D) clocks in every 1024.
- R9: A channel whose enable bit is 0 drives a constant 0 whatever its polarity, weight or dither.
- R10: A new configuration takes effect only at the next period boundary. A pulse in progress finishes with its old width.
- R11: Weight 0 with no extension gives a constant inactive level. Weight 63 with dither 15 gives 1023 active clocks in every 1024.
- R12: Reads of addresses 13–15 return 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the counters, registers and outputs |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Write strobe, captured on the rising clock edge |
| reg_addr | input | 4 | Register address for both read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| pwm_out | output | 8 | Registered channel outputs, one bit per channel |

## Verification
The checker relies on the register port being driven only by synchronous writes that settle well before the sampling edge, and on reg_addr always carrying a defined value. The bench drives every input at the falling edge and keeps reg_we high for exactly one rising edge per write. The properties on the active configuration assume that only the period boundary moves it. The bench therefore writes at arbitrary phases, including in the middle of a running pulse, and leaves at least a full period before it measures.

// File: rtl/pbd_pkg.sv
package pbd_pkg;

    localparam int PBD_CH      = 8;   // channel count
    localparam int PBD_WB      = 6;   // pulse weight bits, period = 2**PBD_WB
    localparam int PBD_BB      = 4;   // dither bits, frame = 2**PBD_BB periods
    localparam int PBD_DW      = 8;   // register data width
    localparam int PBD_POL_BIT = 6;
    localparam int PBD_RSV_BIT = 7;

    typedef logic [PBD_WB-1:0] weight_t;
    typedef logic [PBD_BB-1:0] dith_t;

    typedef struct packed {
        logic    en;
        logic    pol;
        weight_t weight;
        dith_t   dith;
    } ch_cfg_t;

    // One-hot dither bit that owns this frame slot: the lowest set bit p of
    // the frame index selects dither bit (PBD_BB-1-p); slot 0 selects none.
    function automatic dith_t slot_select(input dith_t frame);
        dith_t sel;
        logic  found;
        sel   = '0;
        found = 1'b0;
        for (int p = 0; p < PBD_BB; p++) begin
            if (frame[p] && !found) begin
                sel[PBD_BB-1-p] = 1'b1;
                found           = 1'b1;
            end
        end
        return sel;
    endfunction

    // Active level before polarity: clock 0 carries only the extension,
    // clocks 1..weight carry the base pulse.
    function automatic logic pulse_level(input weight_t phase, input weight_t weight,
                                         input logic ext);
        if (phase == '0) return ext;
        return (phase <= weight);
    endfunction

endpackage

// File: rtl/pbd_timebase.sv
module pbd_timebase
    import pbd_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    output weight_t period_cnt,
    output dith_t   frame_cnt,
    output logic    wrap,
    output dith_t   slot
);

    assign wrap = &period_cnt;
    assign slot = slot_select(frame_cnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            period_cnt <= '0;
            frame_cnt  <= '0;
        end else begin
            period_cnt <= period_cnt + 1'b1;
            if (wrap) begin
                frame_cnt <= frame_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pbd_regs.sv
module pbd_regs
    import pbd_pkg::*;
#(
    parameter int               NUM_CH = PBD_CH,
    parameter logic [NUM_CH-1:0] OE_RST = {1'b1, {(NUM_CH-1){1'b0}}},
    localparam int NUM_PAIR  = NUM_CH / 2,
    localparam int DITH_BASE = NUM_CH,
    localparam int OE_ADDR   = NUM_CH + NUM_PAIR,
    localparam int ADDR_W    = $clog2(OE_ADDR + 1)
)(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   we,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [PBD_DW-1:0]      wdata,
    output logic [PBD_DW-1:0]      rdata,
    output ch_cfg_t [NUM_CH-1:0]   cfg
);

    logic    [NUM_CH-1:0] pol_q;
    weight_t [NUM_CH-1:0] weight_q;
    dith_t   [NUM_CH-1:0] dith_q;
    logic    [NUM_CH-1:0] oe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pol_q    <= '0;
            weight_q <= '0;
            dith_q   <= '0;
            oe_q     <= OE_RST;
        end else if (we) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (addr == ADDR_W'(i)) begin
                    pol_q[i]    <= wdata[PBD_POL_BIT];
                    weight_q[i] <= wdata[PBD_WB-1:0];
                end
            end
            for (int k = 0; k < NUM_PAIR; k++) begin
                if (addr == ADDR_W'(DITH_BASE + k)) begin
                    dith_q[2*k]   <= wdata[PBD_BB-1:0];
                    dith_q[2*k+1] <= wdata[2*PBD_BB-1:PBD_BB];
                end
            end
            if (addr == ADDR_W'(OE_ADDR)) begin
                oe_q <= wdata[NUM_CH-1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr == ADDR_W'(i)) begin
                rdata[PBD_RSV_BIT]  = 1'b1;
                rdata[PBD_POL_BIT]  = pol_q[i];
                rdata[PBD_WB-1:0]   = weight_q[i];
            end
        end
        for (int k = 0; k < NUM_PAIR; k++) begin
            if (addr == ADDR_W'(DITH_BASE + k)) begin
                rdata[PBD_BB-1:0]        = dith_q[2*k];
                rdata[2*PBD_BB-1:PBD_BB] = dith_q[2*k+1];
            end
        end
        if (addr == ADDR_W'(OE_ADDR)) begin
            rdata[NUM_CH-1:0] = oe_q;
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_cfg
        assign cfg[g].en     = oe_q[g];
        assign cfg[g].pol    = pol_q[g];
        assign cfg[g].weight = weight_q[g];
        assign cfg[g].dith   = dith_q[g];
    end

endmodule

// File: rtl/pbd_channel.sv
module pbd_channel
    import pbd_pkg::*;
#(
    parameter logic EN_RST = 1'b0
)(
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  ch_cfg_t cfg_live,
    input  weight_t period_cnt,
    input  dith_t   slot,
    output ch_cfg_t cfg_act,
    output logic    pwm
);

    logic ext;
    logic level;

    assign ext   = |(slot & cfg_act.dith);
    assign level = pulse_level(period_cnt, cfg_act.weight, ext);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_act.en     <= EN_RST;
            cfg_act.pol    <= 1'b0;
            cfg_act.weight <= '0;
            cfg_act.dith   <= '0;
            pwm            <= 1'b0;
        end else begin
            if (load) begin
                cfg_act <= cfg_live;
            end
            pwm <= cfg_act.en & (level ^ cfg_act.pol);
        end
    end

endmodule

// File: rtl/pwm_brm_dac.sv
module pwm_brm_dac
    import pbd_pkg::*;
#(
    parameter int                NUM_CH = PBD_CH,
    parameter logic [NUM_CH-1:0] OE_RST = {1'b1, {(NUM_CH-1){1'b0}}},
    localparam int ADDR_W = $clog2(NUM_CH + NUM_CH/2 + 1)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [PBD_DW-1:0] reg_wdata,
    output logic [PBD_DW-1:0] reg_rdata,
    output logic [NUM_CH-1:0] pwm_out
);

    weight_t              period_cnt;
    dith_t                frame_cnt;
    logic                 wrap;
    dith_t                slot;
    ch_cfg_t [NUM_CH-1:0] cfg_live;
    ch_cfg_t [NUM_CH-1:0] cfg_act;

    pbd_timebase u_timebase (
        .clk        (clk),
        .rst        (rst),
        .period_cnt (period_cnt),
        .frame_cnt  (frame_cnt),
        .wrap       (wrap),
        .slot       (slot)
    );

    pbd_regs #(
        .NUM_CH (NUM_CH),
        .OE_RST (OE_RST)
    ) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .cfg   (cfg_live)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pbd_channel #(
            .EN_RST (OE_RST[g])
        ) u_ch (
            .clk        (clk),
            .rst        (rst),
            .load       (wrap),
            .cfg_live   (cfg_live[g]),
            .period_cnt (period_cnt),
            .slot       (slot),
            .cfg_act    (cfg_act[g]),
            .pwm        (pwm_out[g])
        );
    end

endmodule

// File: rtl/pbd_checker.sv
module pbd_checker
    import pbd_pkg::*;
#(
    parameter int NUM_CH = PBD_CH,
    parameter int ADDR_W = 4
)(
    input logic                 clk,
    input logic                 rst,
    input weight_t              period_cnt,
    input dith_t                frame_cnt,
    input ch_cfg_t [NUM_CH-1:0] cfg_act,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic [PBD_DW-1:0]    reg_rdata,
    input logic [NUM_CH-1:0]    pwm_out
);

    AST_PERIOD_WRAP: assert property (@(posedge clk) disable iff (rst)
        (&period_cnt) |=> (period_cnt == '0) && (frame_cnt == dith_t'($past(frame_cnt) + 1'b1))); // R4

    AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(&period_cnt) |=> $stable(frame_cnt) && (period_cnt == weight_t'($past(period_cnt) + 1'b1))); // R4

    AST_CFG_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        (period_cnt != '0) |-> $stable(cfg_act)); // R10

    AST_RSV_READS_ONE: assert property (@(posedge clk) disable iff (rst)
        (reg_addr < ADDR_W'(NUM_CH)) |-> reg_rdata[PBD_RSV_BIT]); // R2

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_addr > ADDR_W'(NUM_CH + NUM_CH/2)) |-> (reg_rdata == '0)); // R12

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        AST_OFF_IS_LOW: assert property (@(posedge clk) disable iff (rst)
            !cfg_act[g].en |=> !pwm_out[g]); // R9

        AST_ZERO_IS_IDLE: assert property (@(posedge clk) disable iff (rst)
            (cfg_act[g].en && cfg_act[g].weight == '0 && cfg_act[g].dith == '0)
            |=> (pwm_out[g] == $past(cfg_act[g].pol))); // R11
    end

endmodule

bind pwm_brm_dac pbd_checker #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W)
) u_pbd_checker (
    .clk        (clk),
    .rst        (rst),
    .period_cnt (period_cnt),
    .frame_cnt  (frame_cnt),
    .cfg_act    (cfg_act),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .pwm_out    (pwm_out)
);

// File: tb/pwm_brm_dac_bench.sv
`timescale 1ns/1ps
module pwm_brm_dac_bench;

    localparam int CLK_NS = 8;
    localparam int FRAME  = 1024;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [7:0] pwm_out;

    int check_cnt = 0;
    int fail_cnt  = 0;

    int w_cfg [8];
    int d_cfg [8];
    int p_cfg [8];
    logic [7:0] oe_cfg;
    int meas [8];

    always #(CLK_NS/2) clk = ~clk;

    pwm_brm_dac u_pwm_brm_dac (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pwm_out   (pwm_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        check_cnt++;
        if (!ok) begin
            fail_cnt++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_check(input logic [3:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(reg_rdata == exp, req, reg_rdata, exp);
    endtask

    task automatic apply_cfg();
        for (int c = 0; c < 8; c++)
            wr(4'(c), {1'b0, p_cfg[c][0], 6'(w_cfg[c])});
        for (int k = 0; k < 4; k++)
            wr(4'(8 + k), {4'(d_cfg[2*k+1]), 4'(d_cfg[2*k])});
        wr(4'd12, oe_cfg);
        tick(70);
    endtask

    task automatic measure_all();
        for (int c = 0; c < 8; c++) meas[c] = 0;
        repeat (FRAME) begin
            @(negedge clk);
            for (int c = 0; c < 8; c++) meas[c] += int'(pwm_out[c]);
        end
    endtask

    function automatic int expect_cnt(input int c);
        int base;
        base = 16 * w_cfg[c] + d_cfg[c];
        if (!oe_cfg[c]) return 0;
        return (p_cfg[c] != 0) ? FRAME - base : base;
    endfunction

    // R1 R12: reset values, unmapped space, idle outputs
    task automatic t_reset();
        for (int c = 0; c < 8; c++) rd_check(4'(c), 8'h80, "R1 pulse reg reset");
        for (int k = 0; k < 4; k++) rd_check(4'(8 + k), 8'h00, "R1 dither reg reset");
        rd_check(4'd12, 8'h80, "R1 enable reg reset");
        for (int a = 13; a < 16; a++) rd_check(4'(a), 8'h00, "R12 unmapped read");
        measure_all();
        for (int c = 0; c < 8; c++) check(meas[c] == 0, "R11 reset outputs idle", meas[c], 0);
    endtask

    // R2 R3 R12: readback and field placement
    task automatic t_readback();
        wr(4'd3, 8'h00);  rd_check(4'd3, 8'h80, "R2 reserved bit reads one");
        wr(4'd3, 8'h7F);  rd_check(4'd3, 8'hFF, "R2 polarity and weight readback");
        wr(4'd5, 8'h95);  rd_check(4'd5, 8'h95, "R2 bit 7 write ignored");
        wr(4'd9, 8'hA5);  rd_check(4'd9, 8'hA5, "R3 dither pair readback");
        wr(4'd14, 8'hFF);
        rd_check(4'd14, 8'h00, "R12 unmapped write ignored");
        rd_check(4'd12, 8'h80, "R12 enable untouched");
        rd_check(4'd9, 8'hA5, "R12 dither untouched");
    endtask

    // R3 R5 R6 R11: average active counts, non-inverted
    task automatic t_counts();
        int w0 [8] = '{0, 5, 5, 3, 3, 63, 10, 0};
        int d0 [8] = '{0, 9, 1, 2, 4, 15, 8, 8};
        for (int c = 0; c < 8; c++) begin
            w_cfg[c] = w0[c]; d_cfg[c] = d0[c]; p_cfg[c] = 0;
        end
        oe_cfg = 8'hFF;
        apply_cfg();
        measure_all();
        for (int c = 0; c < 8; c++)
            check(meas[c] == expect_cnt(c), "R5 R6 R3 R11 active count", meas[c], expect_cnt(c));
    endtask

    // R8: inverted channels; R9: disabled channels
    task automatic t_polarity_enable();
        p_cfg[1] = 1; p_cfg[6] = 1; p_cfg[0] = 1;
        apply_cfg();
        measure_all();
        for (int c = 0; c < 8; c++)
            check(meas[c] == expect_cnt(c), "R8 inverted count", meas[c], expect_cnt(c));
        oe_cfg = 8'hBC;
        apply_cfg();
        measure_all();
        for (int c = 0; c < 8; c++)
            check(meas[c] == expect_cnt(c), "R9 disabled low", meas[c], expect_cnt(c));
    endtask

    // R7 R4: extension at period start, falling edges every 64 clocks
    task automatic t_edges();
        int last_fall, last_rise, bad_fall, rise_moves, falls;
        logic prev, cur;
        for (int c = 0; c < 8; c++) p_cfg[c] = 0;
        oe_cfg = 8'hFF;
        apply_cfg();
        last_fall = -1; last_rise = -1; bad_fall = 0; rise_moves = 0; falls = 0;
        @(negedge clk); prev = pwm_out[1];
        for (int t = 0; t < 1100; t++) begin
            @(negedge clk); cur = pwm_out[1];
            if (prev && !cur) begin
                if (last_fall >= 0 && t - last_fall != 64) bad_fall++;
                last_fall = t; falls++;
            end
            if (!prev && cur) begin
                if (last_rise >= 0 && t - last_rise != 64) rise_moves++;
                last_rise = t;
            end
            prev = cur;
        end
        check(bad_fall == 0, "R7 R4 fall spacing off 64", bad_fall, 0);
        check(falls >= 16, "R4 periods seen", falls, 16);
        check(rise_moves > 0, "R7 rising edge moves", rise_moves, 1);
    endtask

    // R10: mid-pulse write does not disturb the running pulse
    task automatic t_update();
        int len, bad, runs;
        logic prev, cur;
        wr(4'd6, 8'h0A);
        wr(4'd11, 8'h80);
        tick(70);
        @(negedge clk); prev = pwm_out[6];
        forever begin
            @(negedge clk); cur = pwm_out[6];
            if (!prev && cur) break;
            prev = cur;
        end
        len = 1;
        for (int k = 1; pwm_out[6]; k++) begin
            @(negedge clk);
            if (k == 4) begin reg_we = 1'b1; reg_addr = 4'd6; reg_wdata = 8'h03; end
            else reg_we = 1'b0;
            if (pwm_out[6]) len++;
        end
        reg_we = 1'b0;
        check(len == 10, "R10 running pulse keeps width", len, 10);
        bad = 0; runs = 0; len = 0; prev = 1'b0;
        repeat (300) begin
            @(negedge clk); cur = pwm_out[6];
            if (cur) len++;
            if (prev && !cur) begin
                runs++;
                if (len != 3) bad++;
                len = 0;
            end
            prev = cur;
        end
        check(bad == 0, "R10 new width after boundary", bad, 0);
        check(runs >= 4, "R10 pulses after update", runs, 4);
    endtask

    initial begin
        #(CLK_NS * 200000);
        check_cnt++; fail_cnt++;
        $display("FAIL R4 watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", check_cnt, fail_cnt);
        $finish;
    end

    initial begin
        tick(5);
        rst = 1'b0;
        t_reset();
        t_readback();
        t_counts();
        t_polarity_enable();
        t_edges();
        t_update();
        $display("End of test - %0d assertions evaluated, %0d failures", check_cnt, fail_cnt);
        $finish;
    end

endmodule